// File: doc/BRIEF.md
# Serial Debug Port with Instruction Stuffing

This block is the host-facing end of a debug link into a processor core. A host drives a debug clock, a serial data input and a reset, and sends framed bit streams. Every frame opens with a start bit, then a control bit, then a length bit. The length bit picks a short 7-bit payload or a long 32-bit payload. There is no command decoder. A long payload is an opcode. It is handed straight to the core with a one-cycle execute strobe. While that long payload is shifted in, the port shifts out the 32-bit debug data register on the serial output. That register holds the value the core returned for the previous stuffed opcode. A short payload updates a set of breakpoint control bits.

The port accepts frames only while the core is in debug mode. An exception-style event input puts the core into debug mode. Stuffing the return-from-exception opcode takes it out again. The core itself is outside this block. It is modelled by the strobe, the opcode bus and a result bus.

Top module: `serial_debug_port`

## Requirements
- R1: While `rst_n` is sampled low on a rising edge of `dbg_clk`, the port clears its frame receiver, `bp_ctrl`, the debug data register, `exec_strobe` and `in_debug`. `sdo` is cleared on the next falling edge.
- R2: `in_debug` becomes 1 at the rising edge that samples `dbg_event` high, and it stays 1 until an exit as described in R10.
- R3: While `in_debug` is 0, the serial input is ignored. No strobe is issued, and `bp_ctrl` and the debug data register keep their values.
- R4: A 0 sampled where a start bit is expected is skipped. The receiver keeps waiting until it samples a 1.
- R5: A frame is sent as: start bit 1, then the control bit, then the length bit (1 means a 32-bit payload, 0 means a 7-bit payload), then the payload, most significant bit first. All bits are sampled on rising edges of `dbg_clk`.
- R6: When the last bit of a 32-bit payload is sampled, `exec_strobe` is 1 for exactly the following cycle, and `exec_opcode` carries the assembled payload.
- R7: During a 32-bit payload, `sdo` presents the debug data register most significant bit first. `sdo` changes on falling edges, so the bit that is valid while payload bit k is sampled is register bit 31-k. Outside a 32-bit payload, `sdo` is 0.
- R8: On the rising edge that ends the cycle in which `exec_strobe` is 1, the debug data register captures `core_result`.
- R9: A 7-bit frame with control bit 1 loads its payload into `bp_ctrl`. A 7-bit frame with control bit 0 leaves `bp_ctrl` unchanged. A 7-bit frame never raises `exec_strobe`.
- R10: A 32-bit frame whose payload equals `RET_OPCODE` (default 32'h4C000064) still issues its strobe. It also clears `in_debug` at the same edge that raises `exec_strobe`.
- R11: A 32-bit frame leaves `bp_ctrl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dbg_clk | input | 1 | Host-driven debug clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial frame input, sampled on rising edge |
| sdo | output | 1 | Serial data output, changes on falling edge |
| dbg_event | input | 1 | Exception-style request to enter debug mode |
| in_debug | output | 1 | Debug-mode status |
| exec_strobe | output | 1 | One-cycle request to execute `exec_opcode` |
| exec_opcode | output | 32 | Stuffed opcode for the core |
| core_result | input | 32 | Value returned by the core for the stuffed opcode |
| bp_ctrl | output | 7 | Breakpoint and debug control bits |

## Verification
The bench tracks the debug data register in its own model. Each long frame must shift out the previous result on `sdo`. A port that drove `sdo` one bit late, or shifted it least significant bit first, would show a rotated or mirrored word. Zero bits are placed in front of frames, because a receiver that treated a 0 as a start bit would misalign every field that follows. Three more cases are directed at the frame edges. A short frame with control bit 0 must leave `bp_ctrl` alone, while a design that ignored the control bit would overwrite it. The return opcode must still strobe and must also drop debug mode. Frames sent outside debug mode must have no effect, while a careless design would still strobe or update state.

// File: rtl/sdp_pkg.sv
// Package: shared frame receiver state type for the serial debug port.
// Assumes: nothing beyond IEEE 1800-2017.
package sdp_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_CTRL = 2'd1,
        RX_LEN  = 2'd2,
        RX_BODY = 2'd3
    } rx_state_e;
endpackage

// File: rtl/sdp_frame_rx.sv
// Module: sdp_frame_rx
// Parses start/control/length/payload frames sampled on the rising edge.
// It issues the execute strobe for long frames and writes the breakpoint
// control bits for short frames with control bit 1.
// Assumes: frames are accepted only while `active` is high at the start bit.
module sdp_frame_rx
    import sdp_pkg::*;
#(
    parameter int          LONG_W     = 32,
    parameter int          SHORT_W    = 7,
    parameter logic [31:0] RET_OPCODE = 32'h4C000064
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sdi,
    input  logic               active,
    output logic               exec_strobe,
    output logic [LONG_W-1:0]  exec_opcode,
    output logic [SHORT_W-1:0] bp_ctrl,
    output logic               body_long,
    output logic               len_long_hit,
    output logic               exit_req
);
    localparam int CNT_W = $clog2(LONG_W);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);

    rx_state_e          state;
    logic               ctl_bit;
    logic               is_long;
    logic [CNT_W-1:0]   cnt;
    logic [LONG_W-1:0]  sr;
    logic [LONG_W-1:0]  next_word;
    logic               last_bit;
    logic               long_done;
    logic               short_wr;

    // Combine the shift register with the bit being sampled, and detect frame end.
    always_comb begin
        next_word    = {sr[LONG_W-2:0], sdi};
        last_bit     = is_long ? (cnt == LAST_LONG) : (cnt == LAST_SHORT);
        long_done    = (state == RX_BODY) && is_long && last_bit;
        short_wr     = (state == RX_BODY) && !is_long && last_bit && ctl_bit;
        exit_req     = long_done && (next_word == LONG_W'(RET_OPCODE));
        body_long    = (state == RX_BODY) && is_long;
        len_long_hit = (state == RX_LEN) && sdi;
    end

    // Frame sequencing: start bit, then control bit, length bit and payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            ctl_bit <= 1'b0;
            is_long <= 1'b0;
            cnt     <= '0;
            sr      <= '0;
        end else begin
            case (state)
                RX_IDLE: if (active && sdi) state <= RX_CTRL;
                RX_CTRL: begin
                    ctl_bit <= sdi;
                    state   <= RX_LEN;
                end
                RX_LEN: begin
                    is_long <= sdi;
                    cnt     <= '0;
                    state   <= RX_BODY;
                end
                RX_BODY: begin
                    sr  <= next_word;
                    cnt <= cnt + 1'b1;
                    if (last_bit) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Execute strobe and opcode toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_strobe <= 1'b0;
            exec_opcode <= '0;
        end else begin
            exec_strobe <= long_done;
            if (long_done) exec_opcode <= next_word;
        end
    end

    // Breakpoint control bits written by short frames with control bit 1.
    always_ff @(posedge clk) begin
        if (!rst_n) bp_ctrl <= '0;
        else if (short_wr) bp_ctrl <= next_word[SHORT_W-1:0];
    end

    assert_strobe_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_strobe |=> !exec_strobe);

    assert_idle_when_inactive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && !active) |=> (state == RX_IDLE));

    assert_bp_only_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(bp_ctrl)) |-> $past(short_wr));
endmodule

// File: rtl/sdp_dout.sv
// Module: sdp_dout
// Holds the debug data register. It copies the register into an output shifter
// when a long payload begins, and drives sdo on falling edges.
// Assumes: capture never coincides with a shifter load (frames take longer).
module sdp_dout #(
    parameter int LONG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              body_long,
    input  logic              capture,
    input  logic [LONG_W-1:0] core_result,
    output logic              sdo
);
    logic [LONG_W-1:0] ddr;
    logic [LONG_W-1:0] dshift;

    // Result capture and output shifter, rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ddr    <= '0;
            dshift <= '0;
        end else begin
            if (capture) ddr <= core_result;
            if (load) dshift <= ddr;
            else if (body_long) dshift <= {dshift[LONG_W-2:0], 1'b0};
        end
    end

    // Serial output launched on the falling edge, zero outside long payloads.
    always_ff @(negedge clk) begin
        if (!rst_n) sdo <= 1'b0;
        else        sdo <= body_long ? dshift[LONG_W-1] : 1'b0;
    end

    assert_capture_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (ddr == $past(core_result)));
endmodule

// File: rtl/sdp_mode.sv
// Module: sdp_mode
// Debug-mode flag: set by an exception-style event, cleared by the return opcode.
// Assumes: an exit request takes priority over a coincident event.
module sdp_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic exit_req,
    output logic in_debug
);
    // Debug-mode set/clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        in_debug <= 1'b0;
        else if (exit_req) in_debug <= 1'b0;
        else if (enter)    in_debug <= 1'b1;
    end

    assert_enter_by_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(in_debug)) |-> $past(enter));

    assert_exit_by_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(in_debug)) |-> $past(exit_req));
endmodule

// File: rtl/serial_debug_port.sv
// Module: serial_debug_port (top)
// Serial debug port that stuffs 32-bit opcodes into a core and shifts results out.
// Assumes: the core answers on core_result while exec_strobe is high.
module serial_debug_port #(
    parameter int          LONG_W     = 32,
    parameter int          SHORT_W    = 7,
    parameter logic [31:0] RET_OPCODE = 32'h4C000064
) (
    input  logic               dbg_clk,
    input  logic               rst_n,
    input  logic               sdi,
    output logic               sdo,
    input  logic               dbg_event,
    output logic               in_debug,
    output logic               exec_strobe,
    output logic [LONG_W-1:0]  exec_opcode,
    input  logic [LONG_W-1:0]  core_result,
    output logic [SHORT_W-1:0] bp_ctrl
);
    logic body_long;
    logic len_long_hit;
    logic exit_req;

    sdp_frame_rx #(
        .LONG_W     (LONG_W),
        .SHORT_W    (SHORT_W),
        .RET_OPCODE (RET_OPCODE)
    ) u_rx (
        .clk          (dbg_clk),
        .rst_n        (rst_n),
        .sdi          (sdi),
        .active       (in_debug),
        .exec_strobe  (exec_strobe),
        .exec_opcode  (exec_opcode),
        .bp_ctrl      (bp_ctrl),
        .body_long    (body_long),
        .len_long_hit (len_long_hit),
        .exit_req     (exit_req)
    );

    sdp_dout #(
        .LONG_W (LONG_W)
    ) u_dout (
        .clk         (dbg_clk),
        .rst_n       (rst_n),
        .load        (len_long_hit),
        .body_long   (body_long),
        .capture     (exec_strobe),
        .core_result (core_result),
        .sdo         (sdo)
    );

    sdp_mode u_mode (
        .clk      (dbg_clk),
        .rst_n    (rst_n),
        .enter    (dbg_event),
        .exit_req (exit_req),
        .in_debug (in_debug)
    );
endmodule

// File: tb/sim_serial_debug_port.sv
// Bench for serial_debug_port: a vector table of frames, then directed cases.
module sim_serial_debug_port;
    localparam logic [31:0] RET  = 32'h4C000064;
    localparam logic [31:0] MASK = 32'h5A5AC3C3;
    localparam int NVEC = 8;
    // Entry: {long, ctrl, payload[31:0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 32'h12345678},
        {1'b0, 1'b1, 32'h0000002A},
        {1'b1, 1'b1, 32'hDEADBEEF},
        {1'b0, 1'b0, 32'h00000055},
        {1'b1, 1'b0, 32'h80000001},
        {1'b0, 1'b1, 32'h0000007F},
        {1'b1, 1'b0, 32'h00000000},
        {1'b0, 1'b1, 32'h00000001}
    };

    logic        dbg_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        dbg_event = 1'b0;
    logic        in_debug;
    logic        exec_strobe;
    logic [31:0] exec_opcode;
    logic [31:0] core_result;
    logic [6:0]  bp_ctrl;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model_ddr;
    logic [6:0]  model_bp;
    logic        done = 1'b0;

    always #2 dbg_clk = ~dbg_clk;

    assign core_result = exec_opcode ^ MASK;

    serial_debug_port u0 (
        .dbg_clk(dbg_clk), .rst_n(rst_n), .sdi(sdi), .sdo(sdo),
        .dbg_event(dbg_event), .in_debug(in_debug), .exec_strobe(exec_strobe),
        .exec_opcode(exec_opcode), .core_result(core_result), .bp_ctrl(bp_ctrl)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge dbg_clk); #1;
        sdi = b;
    endtask

    // Sends one frame; returns the word seen on sdo during the payload.
    task automatic send_frame(input logic lng, input logic ctl, input logic [31:0] pl,
                              output logic [31:0] seen);
        int n;
        n = lng ? 32 : 7;
        seen = '0;
        drive_bit(1'b1);
        drive_bit(ctl);
        drive_bit(lng);
        for (int k = n - 1; k >= 0; k--) begin
            drive_bit(pl[k]);
            seen = {seen[30:0], sdo};
        end
        drive_bit(1'b0);
    endtask

    task automatic enter_dbg();
        @(negedge dbg_clk); #1;
        dbg_event = 1'b1;
        @(negedge dbg_clk); #1;
        dbg_event = 1'b0;
        check("R2 in_debug after event", 32'(in_debug), 32'd1);
    endtask

    initial begin
        logic [31:0] seen;
        model_ddr = '0;
        model_bp  = '0;
        repeat (3) @(posedge dbg_clk);
        @(negedge dbg_clk); #1;
        check("R1 sdo reset", 32'(sdo), 32'd0);
        check("R1 in_debug reset", 32'(in_debug), 32'd0);
        check("R1 strobe reset", 32'(exec_strobe), 32'd0);
        check("R1 bp_ctrl reset", 32'(bp_ctrl), 32'd0);
        rst_n = 1'b1;

        // R3: frames before debug mode have no effect.
        send_frame(1'b0, 1'b1, 32'h33, seen);
        check("R3 bp_ctrl untouched", 32'(bp_ctrl), 32'd0);
        send_frame(1'b1, 1'b0, 32'hCAFEF00D, seen);
        check("R3 no strobe", 32'(exec_strobe), 32'd0);

        enter_dbg();
        // R4: leading zeros are skipped before the start bit.
        drive_bit(1'b0); drive_bit(1'b0); drive_bit(1'b0);

        // Vector table walk (R5, R6, R7, R8, R9, R11).
        for (int i = 0; i < NVEC; i++) begin
            logic        lng;
            logic        ctl;
            logic [31:0] pl;
            lng = VEC[i][33];
            ctl = VEC[i][32];
            pl  = VEC[i][31:0];
            send_frame(lng, ctl, pl, seen);
            if (lng) begin
                check("R6 strobe high", 32'(exec_strobe), 32'd1);
                check("R6 opcode", exec_opcode, pl);
                check("R7 sdo word", seen, model_ddr);
                check("R11 bp_ctrl unchanged", 32'(bp_ctrl), 32'(model_bp));
                model_ddr = pl ^ MASK;
                @(posedge dbg_clk); #1;
                check("R6 strobe single cycle", 32'(exec_strobe), 32'd0);
            end else begin
                check("R9 no strobe on short", 32'(exec_strobe), 32'd0);
                check("R7 sdo idle on short", seen, 32'd0);
                if (ctl) model_bp = pl[6:0];
                check("R9 bp_ctrl", 32'(bp_ctrl), 32'(model_bp));
            end
            drive_bit(1'b0);
        end

        // R8: result of last long frame comes out on the next one.
        send_frame(1'b1, 1'b0, 32'h0F0F0F0F, seen);
        check("R8 captured result shifted", seen, model_ddr);
        model_ddr = 32'h0F0F0F0F ^ MASK;
        drive_bit(1'b0);

        // R10: return opcode strobes and leaves debug mode.
        send_frame(1'b1, 1'b0, RET, seen);
        check("R10 strobe on return", 32'(exec_strobe), 32'd1);
        check("R10 in_debug cleared", 32'(in_debug), 32'd0);
        model_ddr = RET ^ MASK;
        send_frame(1'b0, 1'b1, 32'h11, seen);
        check("R3 ignored after exit", 32'(bp_ctrl), 32'(model_bp));

        // R1: reset clears the data register and bp_ctrl.
        @(negedge dbg_clk); #1;
        rst_n = 1'b0;
        @(negedge dbg_clk); #1;
        rst_n = 1'b1;
        check("R1 bp_ctrl cleared", 32'(bp_ctrl), 32'd0);
        check("R1 in_debug cleared", 32'(in_debug), 32'd0);
        enter_dbg();
        send_frame(1'b1, 1'b0, 32'h00000001, seen);
        check("R1 data register cleared", seen, 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge dbg_clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule